// File: doc/BRIEF.md
# Sixteen-bit two-level carry-lookahead adder

This block adds two 16-bit operands and a carry-in, producing a 16-bit sum and a carry-out, with no clock and no storage. The operands are cut into four 4-bit lanes. Every lane forms bit-level generate (AND) and propagate (XOR) terms. It works out its internal carries as flat sums of products of those terms and its own carry-in, so no carry passes from one full adder to the next. It also reports a lane-wide propagate and a lane-wide generate.

A second-level lookahead unit takes the four lane-wide pairs and the adder carry-in. It applies the same flat equations one level up to produce the carries into lanes 1, 2 and 3 and the final carry-out. The worst-case path is therefore two lookahead levels deep, however the carries happen to fall. The adder is meant as a drop-in combinational datapath element where a 16-bit add must settle within one cycle.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, taken as unsigned values.
- R2: `cout_o` equals bit 16 of the 17-bit unsigned total `a_i + b_i + cin_i`.
- R3: With `b_i` equal to the bitwise inverse of `a_i`, every bit propagates. A carry-in of 1 gives `sum_o` = 0x0000 and `cout_o` = 1. A carry-in of 0 gives `sum_o` = 0xFFFF and `cout_o` = 0.
- R4: A carry generated at the top bit of a lane (bits 3, 7 or 11 both set) enters the next lane. For example, 0x0008 + 0x0008 gives 0x0010, and 0x0800 + 0x0800 gives 0x1000.
- R5: Inside each lane, every flat lookahead carry equals the carry that a chain of full adders would produce from the same operands and lane carry-in.
- R6: A lane never reports its lane-wide propagate and its lane-wide generate both high at once.
- R7: Each lane's own top carry equals its lane-wide generate OR (lane-wide propagate AND lane carry-in). The second-level carries equal the chained group form.
- R8: 0xFFFF + 0xFFFF + cin gives `sum_o` = 0xFFFE + cin with `cout_o` = 1. 0x0000 + 0x0000 + cin gives `sum_o` = cin with `cout_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
The two functions that meet in one evaluation are a lane's own carry generation and the carry-in that the second-level unit propagates into that same lane. Either can set the lane's carries, and a wrong term in a flat product shows only when both are active. The sweep puts every 4-bit operand pair into each lane in turn. The other lanes hold an all-propagate, all-generate or all-kill background, under both carry-in values, so a lane-local generate coincides with an incoming propagated carry. Each result is judged against the 17-bit arithmetic sum computed in the bench.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned GRP = 4;

  // Flat lookahead: carry k+1 is an OR of products of g/p terms and c0;
  // no carry term is reused to build the next one.
  function automatic logic [GRP:0] flat_carries(input logic [GRP-1:0] g,
                                                input logic [GRP-1:0] p,
                                                input logic           c0);
    logic [GRP:0] c;
    logic         prod;
    c    = '0;
    c[0] = c0;
    for (int unsigned k = 0; k < GRP; k++) begin
      logic acc;
      acc = 1'b0;
      for (int unsigned j = 0; j <= k; j++) begin
        prod = g[j];
        for (int unsigned m = j + 1; m <= k; m++) prod = prod & p[m];
        acc = acc | prod;
      end
      prod = c0;
      for (int unsigned m = 0; m <= k; m++) prod = prod & p[m];
      c[k+1] = acc | prod;
    end
    return c;
  endfunction

  // Chained form, used only as an independent cross-check.
  function automatic logic [GRP:0] chain_carries(input logic [GRP-1:0] g,
                                                 input logic [GRP-1:0] p,
                                                 input logic           c0);
    logic [GRP:0] c;
    c[0] = c0;
    for (int unsigned k = 0; k < GRP; k++) c[k+1] = g[k] | (p[k] & c[k]);
    return c;
  endfunction

  function automatic logic group_prop(input logic [GRP-1:0] p);
    return &p;
  endfunction

  function automatic logic group_gen(input logic [GRP-1:0] g,
                                     input logic [GRP-1:0] p);
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int unsigned j = 0; j < GRP; j++) begin
      prod = g[j];
      for (int unsigned m = j + 1; m < GRP; m++) prod = prod & p[m];
      acc = acc | prod;
    end
    return acc;
  endfunction

endpackage

// File: rtl/cla_pg_cell.sv
module cla_pg_cell #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prop_o[i] = a_i[i] ^ b_i[i];
  end

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R6 support: a bit can never both generate and propagate
      a_r6_bit_excl: assert ((gen_o & prop_o) == '0)
        else $error("bit generate and propagate overlap");
    end
  end

endmodule

// File: rtl/cla_slice.sv
module cla_slice
  import cla_pkg::*;
(
  input  logic [GRP-1:0] a_i,
  input  logic [GRP-1:0] b_i,
  input  logic           cin_i,
  output logic [GRP-1:0] sum_o,
  output logic           grp_p_o,
  output logic           grp_g_o
);

  logic [GRP-1:0] bit_g;
  logic [GRP-1:0] bit_p;
  logic [GRP:0]   lane_c;
  logic           lane_top_c;

  cla_pg_cell #(.W(GRP)) i_pg (
    .a_i   (a_i),
    .b_i   (b_i),
    .gen_o (bit_g),
    .prop_o(bit_p)
  );

  assign lane_c     = flat_carries(bit_g, bit_p, cin_i);
  assign lane_top_c = lane_c[GRP];
  assign sum_o      = bit_p ^ lane_c[GRP-1:0];
  assign grp_p_o    = group_prop(bit_p);
  assign grp_g_o    = group_gen(bit_g, bit_p);

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      a_r5_flat_vs_chain: assert (lane_c == chain_carries(bit_g, bit_p, cin_i))
        else $error("flat lane carries differ from chained carries");
      a_r6_group_excl: assert (!(grp_p_o && grp_g_o))
        else $error("lane propagate and generate both high");
      a_r7_lane_top: assert (lane_top_c == (grp_g_o | (grp_p_o & cin_i)))
        else $error("lane top carry disagrees with group pair");
    end
  end

endmodule

// File: rtl/cla_group_unit.sv
module cla_group_unit
  import cla_pkg::*;
(
  input  logic [GRP-1:0] grp_p_i,
  input  logic [GRP-1:0] grp_g_i,
  input  logic           c0_i,
  output logic [GRP:1]   carry_o
);

  logic [GRP:0] lvl2_c;

  assign lvl2_c  = flat_carries(grp_g_i, grp_p_i, c0_i);
  assign carry_o = lvl2_c[GRP:1];

  always_comb begin
    if (!$isunknown({grp_p_i, grp_g_i, c0_i})) begin
      a_r7_group_chain: assert (lvl2_c == chain_carries(grp_g_i, grp_p_i, c0_i))
        else $error("second-level carries differ from chained group form");
      a_r6_group_inputs_excl: assert ((grp_p_i & grp_g_i) == '0)
        else $error("group pair overlap at second level");
    end
  end

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = GRP * GRP
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int unsigned NUM_LANES = WIDTH / GRP;

  logic [NUM_LANES-1:0] lane_p;
  logic [NUM_LANES-1:0] lane_g;
  logic [NUM_LANES:0]   lane_cin;
  logic [GRP:1]         lvl2_carry;

  cla_group_unit i_lvl2 (
    .grp_p_i(lane_p),
    .grp_g_i(lane_g),
    .c0_i   (cin_i),
    .carry_o(lvl2_carry)
  );

  assign lane_cin = {lvl2_carry, cin_i};
  assign cout_o   = lane_cin[NUM_LANES];

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    cla_slice i_slice (
      .a_i    (a_i[k*GRP +: GRP]),
      .b_i    (b_i[k*GRP +: GRP]),
      .cin_i  (lane_cin[k]),
      .sum_o  (sum_o[k*GRP +: GRP]),
      .grp_p_o(lane_p[k]),
      .grp_g_o(lane_g[k])
    );
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      a_r1_total: assert ({cout_o, sum_o} ==
                          ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
        else $error("adder total wrong");
      a_r3_full_prop: assert (!((a_i ^ b_i) == '1) || (cout_o == cin_i))
        else $error("carry-in not propagated across all bits");
    end
  end

endmodule

// File: tb/test_cla16_adder.sv
`timescale 1ns/1ps
module test_cla16_adder;

  logic        clk = 1'b0;
  logic [15:0] a, b, sum;
  logic        cin, cout;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cla16_adder i_cla16_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic apply(input logic [15:0] av, input logic [15:0] bv,
                       input logic cv, input string req);
    logic [16:0] exp;
    @(negedge clk);
    a = av; b = bv; cin = cv;
    @(posedge clk);
    #1;
    exp = {1'b0, av} + {1'b0, bv} + {16'd0, cv};
    checks = checks + 1;
    if ({cout, sum} !== exp) begin
      errors = errors + 1;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
               req, av, bv, cv, {cout, sum}, exp);
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    // Idle/zero state, R8
    apply(16'h0000, 16'h0000, 1'b0, "R8 zero");
    apply(16'h0000, 16'h0000, 1'b1, "R8 zero cin");
    apply(16'hFFFF, 16'hFFFF, 1'b0, "R8 ones");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R8 ones cin");
    // R3 full propagate chain
    apply(16'hA5C3, 16'h5A3C, 1'b1, "R3 prop cin1");
    apply(16'hA5C3, 16'h5A3C, 1'b0, "R3 prop cin0");
    apply(16'hFFFF, 16'h0000, 1'b1, "R3 ones+cin");
    // R4 generate at lane top crosses into next lane
    apply(16'h0008, 16'h0008, 1'b0, "R4 lane0->1");
    apply(16'h0080, 16'h0080, 1'b0, "R4 lane1->2");
    apply(16'h0800, 16'h0800, 1'b0, "R4 lane2->3");
    apply(16'h8000, 16'h8000, 1'b0, "R2 top generate");
    // R5 R6 R7 R1 R2: every operand pair in every lane over three
    // backgrounds (kill, propagate, generate) and both carry-ins
    for (int lane = 0; lane < 4; lane++) begin
      for (int bg = 0; bg < 3; bg++) begin
        for (int cv = 0; cv < 2; cv++) begin
          for (int x = 0; x < 256; x++) begin
            logic [15:0] av, bv;
            case (bg)
              0: begin av = 16'h0000; bv = 16'h0000; end
              1: begin av = 16'hFFFF; bv = 16'h0000; end
              default: begin av = 16'hFFFF; bv = 16'hFFFF; end
            endcase
            av[lane*4 +: 4] = x[3:0];
            bv[lane*4 +: 4] = x[7:4];
            apply(av, bv, cv[0], "R1 R2 R5 R6 R7 lane sweep");
          end
        end
      end
    end
    // R1 R2 pseudo-random operands
    begin
      logic [31:0] lfsr = 32'hACE1_1234;
      for (int n = 0; n < 3000; n++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        apply(lfsr[15:0], lfsr[31:16] ^ 16'h3C5A, lfsr[7], "R1 R2 random");
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule